// File: doc/BRIEF.md
# SD Card SPI-Mode Initialization Sequencer

This block takes an SD card from power-up to the point where block transfers over SPI may begin. After a start pulse it asks an external byte-level command engine to clock idle bytes with chip select high, then walks through the reset, interface-condition, capacity-negotiation and block-length commands. Each step is handed to the engine as one request. The sequencer then waits for the engine's done or timeout strobe and branches on the returned R1 status byte.

The interface-condition response decides between two paths. Legacy cards run a plain application-initialize loop. Newer cards run a paced loop that reads the operating-conditions register, adds a high-capacity hint to the initialize argument, and reads the register once more after success. The block reports a card-type code and whether block numbers must be scaled to byte addresses. It also drives a clock-rate select that stays slow until setup has completed.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, no request is issued, `card_type` is 0, and `addr_scale`, `init_done`, `init_err` and `spi_fast` are all low.
- R2: A start pulse first requests an idle preamble (`eng_idle`=1, `eng_cmd`=0). After that comes command 0 with argument 0 and check byte 0x95. Any response other than 0x01 ends in failure.
- R3: Command 8 is then sent with argument 0x000001AA and check byte 0x87. A response of 0x01 selects the newer-card path and 0x05 selects the legacy path. Every other value fails with `card_type`=0. All commands other than 8 carry check byte 0x95.
- R4: On the legacy path, command 55 (argument 0) and command 41 (argument 0) repeat until command 41 returns 0x00. The path then goes straight to block-length setup and ends with `card_type`=1 and `addr_scale`=1. Each command is requested one engine-done cycle after the previous one.
- R5: On the newer-card path, each attempt first idles DELAY_MS milliseconds of CLK_HZ, so a request follows the previous done by DELAY_CYC+1 cycles. It then issues command 58, command 55 and command 41 with argument 0x40000000. After a 0x00 result, command 58 is issued once more. The path ends with `card_type`=2 and `addr_scale`=0.
- R6: If command 41 has returned a non-zero value MAX_TRIES times, the sequence fails and no further request is made.
- R7: Block-length setup is command 16 with argument 512. A non-zero response fails the sequence.
- R8: A timeout strobe at any step ends the sequence at once with `init_err`=1, `card_type`=0 and `addr_scale`=0.
- R9: `spi_fast` is low throughout the sequence and rises together with `init_done`. `init_done` and `init_err` are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin initialization (accepted when idle, done or failed) |
| eng_req | output | 1 | One-cycle request to the command engine |
| eng_idle | output | 1 | Request is the chip-select-high idle preamble |
| eng_cmd | output | 6 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_crc | output | 8 | Final command byte (check value plus stop bit) |
| eng_done | input | 1 | Engine finished, response valid |
| eng_timeout | input | 1 | Engine saw no response |
| eng_resp | input | 8 | R1 status byte |
| card_type | output | 2 | 0 fail, 1 legacy, 2 newer card |
| addr_scale | output | 1 | Multiply block numbers by 512 |
| init_done | output | 1 | Setup complete |
| init_err | output | 1 | Setup failed |
| spi_fast | output | 1 | Select the fast SPI clock |

## Verification
The hardest condition to reach is retry exhaustion on the paced path. With real settings it needs thousands of 50 ms waits. The bench shrinks the clock frequency parameter and the attempt limit so that the limit is hit after a few short delays. It measures the gap before every attempt against DELAY_CYC+1. A scripted responder also injects a timeout at every position of a full run and sweeps every response value for the reset and interface-condition commands.

// File: rtl/sd_init_seq.sv
module sd_init_seq #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int DELAY_MS  = 50,
  parameter int MAX_TRIES = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        eng_req,
  output logic        eng_idle,
  output logic [5:0]  eng_cmd,
  output logic [31:0] eng_arg,
  output logic [7:0]  eng_crc,
  input  logic        eng_done,
  input  logic        eng_timeout,
  input  logic [7:0]  eng_resp,
  output logic [1:0]  card_type,
  output logic        addr_scale,
  output logic        init_done,
  output logic        init_err,
  output logic        spi_fast
);
  localparam int DELAY_CYC = (CLK_HZ / 1000) * DELAY_MS;
  localparam int DW = $clog2(DELAY_CYC + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_C0, S_C8, S_V1_55, S_V1_41, S_V2_WAIT, S_V2_58,
    S_V2_55, S_V2_41, S_V2_58F, S_C16, S_DONE, S_FAIL
  } st_t;

  st_t           state, nxt;
  logic          wait_r;
  logic [DW-1:0] dly;
  logic [TW-1:0] tries;

  wire is_cmd   = !(state inside {S_IDLE, S_DONE, S_FAIL, S_V2_WAIT});
  wire ack      = wait_r && eng_done;
  wire tmo      = wait_r && eng_timeout;
  wire last_try = (tries == TW'(MAX_TRIES - 1));
  wire resp_ok  = (eng_resp == 8'h00);

  assign eng_req   = is_cmd && !wait_r;
  assign eng_idle  = (state == S_PRE);
  assign eng_crc   = (state == S_C8) ? 8'h87 : 8'h95;
  assign init_done = (state == S_DONE);
  assign init_err  = (state == S_FAIL);

  always_comb begin
    eng_cmd = 6'd0;
    eng_arg = 32'd0;
    case (state)
      S_C8:              begin eng_cmd = 6'd8;  eng_arg = 32'h0000_01AA; end
      S_V1_55, S_V2_55:        eng_cmd = 6'd55;
      S_V1_41:                 eng_cmd = 6'd41;
      S_V2_41:           begin eng_cmd = 6'd41; eng_arg = 32'h4000_0000; end
      S_V2_58, S_V2_58F:       eng_cmd = 6'd58;
      S_C16:             begin eng_cmd = 6'd16; eng_arg = 32'd512; end
      default: ;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE, S_DONE, S_FAIL: if (start) nxt = S_PRE;
      S_V2_WAIT:              if (dly == '0) nxt = S_V2_58;
      default:
        if (tmo) nxt = S_FAIL;
        else if (ack) begin
          case (state)
            S_PRE:    nxt = S_C0;
            S_C0:     nxt = (eng_resp == 8'h01) ? S_C8 : S_FAIL;
            S_C8:     nxt = (eng_resp == 8'h01) ? S_V2_WAIT :
                            (eng_resp == 8'h05) ? S_V1_55 : S_FAIL;
            S_V1_55:  nxt = S_V1_41;
            S_V1_41:  nxt = resp_ok ? S_C16 : (last_try ? S_FAIL : S_V1_55);
            S_V2_58:  nxt = S_V2_55;
            S_V2_55:  nxt = S_V2_41;
            S_V2_41:  nxt = resp_ok ? S_V2_58F : (last_try ? S_FAIL : S_V2_WAIT);
            S_V2_58F: nxt = S_C16;
            S_C16:    nxt = resp_ok ? S_DONE : S_FAIL;
            default:  nxt = S_FAIL;
          endcase
        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wait_r     <= 1'b0;
      dly        <= '0;
      tries      <= '0;
      card_type  <= 2'd0;
      addr_scale <= 1'b0;
      spi_fast   <= 1'b0;
    end else begin
      state    <= nxt;
      spi_fast <= (nxt == S_DONE);
      if (nxt != state)  wait_r <= 1'b0;
      else if (eng_req)  wait_r <= 1'b1;
      if (nxt == S_V2_WAIT && state != S_V2_WAIT) dly <= DW'(DELAY_CYC - 1);
      else if (state == S_V2_WAIT && dly != '0)   dly <= dly - 1'b1;
      if (state == S_C8) tries <= '0;
      else if (ack && (state inside {S_V1_41, S_V2_41}) && !resp_ok && !last_try)
        tries <= tries + 1'b1;
      if (nxt == S_FAIL || nxt == S_PRE) begin
        card_type  <= 2'd0;
        addr_scale <= 1'b0;
      end else if (state == S_C8 && ack) begin
        if (eng_resp == 8'h01)      begin card_type <= 2'd2; addr_scale <= 1'b0; end
        else if (eng_resp == 8'h05) begin card_type <= 2'd1; addr_scale <= 1'b1; end
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req); // R2
  AST_DELAY_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_V2_58 && $past(state) == S_V2_WAIT) |-> $past(dly) == '0); // R5
  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TW'(MAX_TRIES)); // R6
  AST_DONE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (card_type != 2'd0 && addr_scale == (card_type == 2'd1))); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |-> (card_type == 2'd0 && !addr_scale)); // R8
  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_fast == init_done && !(init_done && init_err)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !start) |=> init_done); // R9
endmodule

// File: tb/sd_init_seq_tb_top.sv
module sd_init_seq_tb_top;
  localparam int CLK_HZ = 20_000, DELAY_MS = 1, MAX_TRIES = 4;
  localparam int DCYC = (CLK_HZ / 1000) * DELAY_MS;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic eng_req, eng_idle, eng_done = 0, eng_timeout = 0;
  logic [5:0] eng_cmd; logic [31:0] eng_arg; logic [7:0] eng_crc, eng_resp = 0;
  logic [1:0] card_type; logic addr_scale, init_done, init_err, spi_fast;

  always #2 clk = ~clk;

  sd_init_seq #(.CLK_HZ(CLK_HZ), .DELAY_MS(DELAY_MS), .MAX_TRIES(MAX_TRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .eng_req(eng_req), .eng_idle(eng_idle),
    .eng_cmd(eng_cmd), .eng_arg(eng_arg), .eng_crc(eng_crc), .eng_done(eng_done),
    .eng_timeout(eng_timeout), .eng_resp(eng_resp), .card_type(card_type),
    .addr_scale(addr_scale), .init_done(init_done), .init_err(init_err), .spi_fast(spi_fast));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [46:0] exp_e [64]; int exp_g [64]; int exp_n;
  logic [46:0] got_e [64]; int got_g [64]; int got_n;
  bit stop; int to_idx;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [46:0] mk(input bit idle, input int cmd, input logic [31:0] arg);
    return {idle, 6'(cmd), arg, (cmd == 8 && !idle) ? 8'h87 : 8'h95};
  endfunction

  task automatic push(input logic [46:0] e, input int g);
    exp_e[exp_n] = e; exp_g[exp_n] = g;
    if (exp_n == to_idx) stop = 1;
    exp_n++;
  endtask

  task automatic run(input string tag, input logic [7:0] r0, input logic [7:0] r8,
                     input int nfail, input logic [7:0] r16, input int to_at);
    int tp, a, acmd; bit succ, ok_seq, ex_ok;
    int gap;
    logic [63:0] ba, be;
    exp_n = 0; stop = 0; to_idx = to_at; succ = 0; tp = 0; ex_ok = 0;
    push(mk(1, 0, 0), 0);
    if (!stop) push(mk(0, 0, 0), 1);
    if (!stop && r0 == 8'h01) begin
      push(mk(0, 8, 32'h1AA), 1);
      if (!stop && r8 == 8'h05) begin
        tp = 1;
        for (a = 0; a < MAX_TRIES && !stop && !succ; a++) begin
          push(mk(0, 55, 0), 1);
          if (!stop) push(mk(0, 41, 0), 1);
          if (!stop && a >= nfail) succ = 1;
        end
      end else if (!stop && r8 == 8'h01) begin
        tp = 2;
        for (a = 0; a < MAX_TRIES && !stop && !succ; a++) begin
          push(mk(0, 58, 0), DCYC + 1);
          if (!stop) push(mk(0, 55, 0), 1);
          if (!stop) push(mk(0, 41, 32'h4000_0000), 1);
          if (!stop && a >= nfail) succ = 1;
        end
        if (succ && !stop) push(mk(0, 58, 0), 1);
      end
      if (succ && !stop) begin
        push(mk(0, 16, 512), 1);
        if (!stop && r16 == 8'h00) ex_ok = 1;
      end
    end

    got_n = 0; acmd = 0; gap = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    for (int guard = 0; guard < 2000; guard++) begin
      if (init_done || init_err) break;
      if (eng_req) begin
        if (got_n < 64) begin
          got_e[got_n] = {eng_idle, eng_cmd, eng_arg, eng_crc}; got_g[got_n] = gap;
        end
        if (spi_fast) chk(0, "R9", "fast during run", 1, 0);
        repeat (LAT) @(negedge clk);
        if (got_n == to_at) eng_timeout = 1;
        else begin
          eng_done = 1;
          if (eng_idle) eng_resp = 8'hFF;
          else case (eng_cmd)
            6'd0:  eng_resp = r0;
            6'd8:  eng_resp = r8;
            6'd41: begin eng_resp = (acmd >= nfail) ? 8'h00 : 8'h01; acmd++; end
            6'd16: eng_resp = r16;
            6'd55: eng_resp = 8'h01;
            default: eng_resp = 8'h00;
          endcase
        end
        got_n++; gap = 0;
      end
      @(negedge clk); gap++; eng_done = 0; eng_timeout = 0;
    end
    repeat (3) @(negedge clk);
    ok_seq = (got_n == exp_n); ba = 64'(got_n); be = 64'(exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++)
      if (ok_seq && (got_e[i] != exp_e[i] || (i > 0 && got_g[i] != exp_g[i]))) begin
        ok_seq = 0;
        ba = {got_e[i][46:0], 17'(got_g[i])} ; be = {exp_e[i][46:0], 17'(exp_g[i])};
      end
    chk(ok_seq, tag, "request sequence", ba, be);
    chk({init_done, init_err, card_type, addr_scale} ==
        (ex_ok ? {1'b1, 1'b0, 2'(tp), tp == 1} : 5'b01000), tag, "outcome",
        {init_done, init_err, card_type, addr_scale},
        ex_ok ? {1'b1, 1'b0, 2'(tp), tp == 1} : 5'b01000);
    chk(spi_fast == ex_ok && !(init_done && init_err), "R9", "fast select", spi_fast, ex_ok);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!eng_req && card_type == 0 && !addr_scale && !init_done && !init_err && !spi_fast,
        "R1", "reset outputs", {eng_req, card_type, addr_scale, init_done, init_err, spi_fast}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!eng_req && !init_done && !init_err, "R1", "idle without start",
        {eng_req, init_done, init_err}, 0);
    run("R4", 8'h01, 8'h05, 0, 8'h00, -1);
    run("R4", 8'h01, 8'h05, 2, 8'h00, -1);
    run("R5", 8'h01, 8'h01, 0, 8'h00, -1);
    run("R5", 8'h01, 8'h01, 3, 8'h00, -1);
    run("R6", 8'h01, 8'h05, MAX_TRIES, 8'h00, -1);
    run("R6", 8'h01, 8'h01, MAX_TRIES, 8'h00, -1);
    run("R7", 8'h01, 8'h05, 1, 8'h04, -1);
    run("R7", 8'h01, 8'h01, 1, 8'h40, -1);
    for (int v = 0; v < 256; v++) run("R2", 8'(v), 8'h01, 0, 8'h00, -1);
    for (int v = 0; v < 256; v++) run("R3", 8'h01, 8'(v), 0, 8'h00, -1);
    for (int t = 0; t < 12; t++) run("R8", 8'h01, 8'h01, 1, 8'h00, t);
    for (int t = 0; t < 8; t++) run("R8", 8'h01, 8'h05, 1, 8'h00, t);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule